// File: doc/BRIEF.md
# Soft-Stepped Volume Controller with Constant-Input Mute

This block computes the gain code applied to a mono audio channel. Software programs a signed target volume in half-decibel units. The block does not jump to that target. It walks the applied code toward it one half-decibel at a time, and each step is paced by a word-clock strobe that marks every audio sample. A mode input sets the pace. The block can take one step per sample, one step per two samples, or jump straight to the target.

The same strobe drives a run detector that watches the incoming sample value. When the same value has arrived more times in a row than a selectable threshold, the channel is muted automatically. That automatic mute is combined with a manual mute bit into one registered mute output. A status flag tells software when the applied code has reached the programmed one. The downstream multiplier uses the gain code and the mute output and is not part of this block.

Top module: `gain_ramp_top`

## Requirements
- R1: While reset is held and right after it, gain_code is 0x00 (0 dB), mute_eff is 1, the step pacer is cleared and the run detector holds no run.
- R2: vol_code is read as signed two's complement in 0.5 dB units. Values above 0x30 (0x31..0x7F) are treated as 0x30 (+24 dB) and 0x80 as 0x81 (-63.5 dB). gain_code never holds 0x31..0x80.
- R3: With step_mode 00, each strobe moves gain_code by exactly one code toward the clamped target.
- R4: With step_mode 01, the applied code moves one code on every second strobe. The first strobe after the code has settled does not step.
- R5: With step_mode 10, and also with the reserved 11, gain_code takes the clamped target on the next strobe.
- R6: gain_code changes only on a clock edge where fs_stb is 1.
- R7: If the target changes during a ramp, stepping continues from the current applied code toward the new target.
- R8: gain_settled is 1 exactly when gain_code equals the clamped target.
- R9: amute_sel 0 disables the automatic mute. A value k from 1 to 7 mutes once the current run of identical samples (the first sample of the run counts as 1) is longer than DC_BASE·2^(k-1).
- R10: A strobed sample that differs from the one before it restarts the run at length 1, which releases the automatic mute.
- R11: mute_eff is a register that takes mute_man OR the automatic mute one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_stb | input | 1 | One-cycle word-clock strobe, one per sample |
| sample_in | input | SAMPLE_W | Input sample, valid with fs_stb |
| vol_code | input | CODE_W | Programmed volume, signed 0.5 dB units |
| step_mode | input | 2 | 00 every strobe, 01 every second strobe, 10/11 jump |
| mute_man | input | 1 | Manual mute request |
| amute_sel | input | 3 | Constant-input mute threshold select |
| gain_code | output | CODE_W | Applied gain code |
| mute_eff | output | 1 | Effective mute |
| gain_settled | output | 1 | Applied code equals programmed code |

## Verification
The bench builds the block with DC_BASE set to 3, so the seven run thresholds become 3, 6, 12, 24, 48, 96 and 192 samples. Every threshold, the edge around it, and the run counter's saturation can then be reached in a few thousand cycles. The code width stays at 8, so the clamp is swept over all 256 volume codes. Ramps are driven across the full legal span in both directions.

// File: rtl/gr_pkg.sv
package gr_pkg;
  typedef enum logic [1:0] {
    STEP_EVERY = 2'b00,
    STEP_ALT   = 2'b01,
    STEP_JUMP  = 2'b10,
    STEP_RSVD  = 2'b11
  } step_mode_e;
endpackage

// File: rtl/gr_target_clamp.sv
module gr_target_clamp #(
  parameter int CODE_W   = 8,
  parameter int MAX_CODE = 48
) (
  input  logic [CODE_W-1:0]        vol_code,
  output logic signed [CODE_W-1:0] target
);
  localparam logic signed [CODE_W-1:0] HI = CODE_W'(MAX_CODE);
  localparam logic signed [CODE_W-1:0] LO = {1'b1, {(CODE_W-2){1'b0}}, 1'b1};

  logic signed [CODE_W-1:0] v;
  assign v = vol_code;

  always_comb begin
    if (v > HI)      target = HI;
    else if (v < LO) target = LO;
    else             target = v;
  end
endmodule

// File: rtl/gr_ramp.sv
module gr_ramp
  import gr_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fs_stb,
  input  logic [1:0]               step_mode,
  input  logic signed [CODE_W-1:0] target,
  output logic signed [CODE_W-1:0] gain_q,
  output logic                     settled
);
  logic signed [CODE_W-1:0] gain_n;
  logic                     phase_q, phase_n;
  step_mode_e               mode;

  assign mode    = step_mode_e'(step_mode);
  assign settled = (gain_q == target);

  always_comb begin
    gain_n  = gain_q;
    phase_n = phase_q;
    if (fs_stb) begin
      if (mode == STEP_JUMP || mode == STEP_RSVD) begin
        gain_n  = target;
        phase_n = 1'b0;
      end else if (gain_q == target) begin
        phase_n = 1'b0;
      end else if (mode == STEP_ALT && !phase_q) begin
        phase_n = 1'b1;
      end else begin
        phase_n = 1'b0;
        if (gain_q < target) gain_n = gain_q + CODE_W'(1);
        else                 gain_n = gain_q - CODE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gain_q  <= '0;
      phase_q <= 1'b0;
    end else if (fs_stb) begin
      gain_q  <= gain_n;
      phase_q <= phase_n;
    end
  end
endmodule

// File: rtl/gr_dc_detect.sv
module gr_dc_detect #(
  parameter int SAMPLE_W = 16,
  parameter int SEL_W    = 3,
  parameter int DC_BASE  = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fs_stb,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [SEL_W-1:0]    amute_sel,
  output logic                dc_hit
);
  localparam int NSEL    = 1 << SEL_W;
  localparam int CNT_MAX = DC_BASE * (1 << (NSEL - 2)) + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [CNT_W-1:0]    thr [NSEL];
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [SAMPLE_W-1:0] prev_q;

  for (genvar k = 0; k < NSEL; k++) begin : g_thr
    if (k == 0) begin : g_off
      assign thr[k] = '0;
    end else begin : g_on
      assign thr[k] = CNT_W'(DC_BASE << (k - 1));
    end
  end

  always_comb begin
    cnt_n = cnt_q;
    if (cnt_q == '0 || sample_in != prev_q) cnt_n = CNT_W'(1);
    else if (cnt_q != CNT_W'(CNT_MAX))      cnt_n = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      prev_q <= '0;
    end else if (fs_stb) begin
      cnt_q  <= cnt_n;
      prev_q <= sample_in;
    end
  end

  assign dc_hit = (amute_sel != '0) && (cnt_q > thr[amute_sel]);
endmodule

// File: rtl/gain_ramp_top.sv
module gain_ramp_top #(
  parameter int CODE_W   = 8,
  parameter int SAMPLE_W = 16,
  parameter int MAX_CODE = 48,
  parameter int DC_BASE  = 100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fs_stb,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic [CODE_W-1:0]   vol_code,
  input  logic [1:0]          step_mode,
  input  logic                mute_man,
  input  logic [2:0]          amute_sel,
  output logic [CODE_W-1:0]   gain_code,
  output logic                mute_eff,
  output logic                gain_settled
);
  logic signed [CODE_W-1:0] target;
  logic signed [CODE_W-1:0] gain_q;
  logic                     dc_hit;
  logic                     mute_q;

  gr_target_clamp #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_clamp (
    .vol_code (vol_code),
    .target   (target)
  );

  gr_ramp #(.CODE_W(CODE_W)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_stb    (fs_stb),
    .step_mode (step_mode),
    .target    (target),
    .gain_q    (gain_q),
    .settled   (gain_settled)
  );

  gr_dc_detect #(.SAMPLE_W(SAMPLE_W), .SEL_W(3), .DC_BASE(DC_BASE)) u_dc (
    .clk       (clk),
    .rst_n     (rst_n),
    .fs_stb    (fs_stb),
    .sample_in (sample_in),
    .amute_sel (amute_sel),
    .dc_hit    (dc_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mute_q <= 1'b1;
    else        mute_q <= mute_man | dc_hit;
  end

  assign gain_code = gain_q;
  assign mute_eff  = mute_q;
endmodule

// File: rtl/gr_checker.sv
module gr_checker #(
  parameter int CODE_W   = 8,
  parameter int MAX_CODE = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fs_stb,
  input logic [1:0]        step_mode,
  input logic              mute_man,
  input logic [CODE_W-1:0] gain_code,
  input logic              mute_eff,
  input logic              gain_settled
);
  logic [CODE_W-1:0]   g_prev;
  logic signed [CODE_W:0] d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) g_prev <= '0;
    else        g_prev <= gain_code;
  end

  assign d = $signed({gain_code[CODE_W-1], gain_code}) - $signed({g_prev[CODE_W-1], g_prev});

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_stb |=> $stable(gain_code));

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($signed(gain_code) > MAX_CODE) && (gain_code != {1'b1, {(CODE_W-1){1'b0}}}));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_stb && step_mode == 2'b00 && !gain_settled) |=>
      (d == (CODE_W+1)'(1) || d == {(CODE_W+1){1'b1}}));

  // R11
  mute_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mute_man |=> mute_eff);
endmodule

bind gain_ramp_top gr_checker #(.CODE_W(CODE_W), .MAX_CODE(MAX_CODE)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fs_stb       (fs_stb),
  .step_mode    (step_mode),
  .mute_man     (mute_man),
  .gain_code    (gain_code),
  .mute_eff     (mute_eff),
  .gain_settled (gain_settled)
);

// File: tb/gain_ramp_top_tb.sv
module gain_ramp_top_tb;
  localparam int DCB = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs_stb = 1'b0;
  logic [15:0] sample_in = '0;
  logic [7:0]  vol_code = '0;
  logic [1:0]  step_mode = 2'b00;
  logic        mute_man = 1'b1;
  logic [2:0]  amute_sel = '0;
  logic [7:0]  gain_code;
  logic        mute_eff, gain_settled;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gain_ramp_top #(.DC_BASE(DCB)) u_dut (
    .clk(clk), .rst_n(rst_n), .fs_stb(fs_stb), .sample_in(sample_in),
    .vol_code(vol_code), .step_mode(step_mode), .mute_man(mute_man),
    .amute_sel(amute_sel), .gain_code(gain_code), .mute_eff(mute_eff),
    .gain_settled(gain_settled)
  );

  function automatic int clampv(input int c);
    int s;
    s = (c > 127) ? c - 256 : c;
    if (s > 48)   s = 48;
    if (s < -127) s = -127;
    return s;
  endfunction

  function automatic int sg(input logic [7:0] v);
    return $signed(v);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    @(negedge clk) fs_stb = 1'b1;
    @(negedge clk) fs_stb = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int g;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(gain_code == 8'h00, "R1 gain", gain_code, 0);
    chk(mute_eff == 1'b1, "R1 mute", mute_eff, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mute_eff == 1'b1, "R1 mute after release", mute_eff, 1);
    chk(gain_settled == 1'b1, "R8 settled at 0", gain_settled, 1);

    // R11 manual mute release and reassert
    mute_man = 1'b0;
    @(negedge clk);
    chk(mute_eff == 1'b0, "R11 unmute", mute_eff, 0);
    mute_man = 1'b1;
    chk(mute_eff == 1'b0, "R11 one clock lag", mute_eff, 0);
    @(negedge clk);
    chk(mute_eff == 1'b1, "R11 mute", mute_eff, 1);

    // R2 R5 clamp sweep in jump mode
    step_mode = 2'b10;
    for (int c = 0; c < 256; c++) begin
      vol_code = 8'(c);
      strobe();
      chk(sg(gain_code) == clampv(c), "R2 R5 clamp", sg(gain_code), clampv(c));
      chk(gain_settled, "R8 settled after jump", gain_settled, 1);
    end
    step_mode = 2'b11;
    vol_code = 8'h10;
    strobe();
    chk(sg(gain_code) == 16, "R5 reserved mode jumps", sg(gain_code), 16);

    // R3 up ramp across full range
    step_mode = 2'b10;
    vol_code = 8'h80;
    strobe();
    step_mode = 2'b00;
    vol_code = 8'h7F;
    @(negedge clk);
    chk(!gain_settled, "R8 unsettled", gain_settled, 0);
    // R6 no motion without strobe
    repeat (10) @(negedge clk);
    chk(sg(gain_code) == -127, "R6 hold", sg(gain_code), -127);
    for (int i = 1; i <= 175; i++) begin
      strobe();
      chk(sg(gain_code) == -127 + i, "R3 up step", sg(gain_code), -127 + i);
      chk(gain_settled == (i == 175), "R8 up ramp flag", gain_settled, int'(i == 175));
    end
    vol_code = 8'hF0;
    for (int i = 1; i <= 64; i++) begin
      strobe();
      chk(sg(gain_code) == 48 - i, "R3 down step", sg(gain_code), 48 - i);
    end
    chk(gain_settled, "R8 down settled", gain_settled, 1);

    // R4 alternate strobes
    step_mode = 2'b01;
    vol_code = 8'h10;
    for (int j = 1; j <= 64; j++) begin
      strobe();
      chk(sg(gain_code) == -16 + j / 2, "R4 half rate", sg(gain_code), -16 + j / 2);
    end
    chk(gain_settled, "R4 settled", gain_settled, 1);

    // R7 retarget mid-ramp
    step_mode = 2'b00;
    vol_code = 8'd40;
    repeat (5) strobe();
    chk(sg(gain_code) == 21, "R7 partial", sg(gain_code), 21);
    vol_code = 8'h00;
    g = 21;
    for (int i = 0; i < 21; i++) begin
      strobe();
      g--;
      chk(sg(gain_code) == g, "R7 new direction", sg(gain_code), g);
    end
    chk(gain_settled, "R7 settled", gain_settled, 1);

    // R9 R10 constant-input mute
    mute_man = 1'b0;
    for (int sel = 1; sel <= 7; sel++) begin
      int thr;
      thr = DCB << (sel - 1);
      amute_sel = 3'(sel);
      sample_in = 16'(sel * 100);
      for (int l = 1; l <= thr + 2; l++) begin
        strobe();
        @(negedge clk);
        chk(mute_eff == (l > thr), "R9 threshold", mute_eff, int'(l > thr));
      end
      sample_in = 16'(sel * 100 + 1);
      strobe();
      @(negedge clk);
      chk(mute_eff == 1'b0, "R10 release", mute_eff, 0);
    end
    amute_sel = 3'd0;
    sample_in = 16'h1234;
    for (int l = 1; l <= 300; l++) strobe();
    @(negedge clk);
    chk(mute_eff == 1'b0, "R9 disabled", mute_eff, 0);
    amute_sel = 3'd7;
    @(negedge clk);
    @(negedge clk);
    chk(mute_eff == 1'b1, "R9 saturated run", mute_eff, 1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule